// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Qualification and Power Save

This block sits between the two dividers of a frequency synthesizer and the charge pump. It watches the rising edges of the divided reference signal and of the divided oscillator signal. It turns the time between those edges into pump commands. A pair of active-low pulse outputs can drive an external charge pump. An enable and a direction signal steer an internal pump, whose output goes to high impedance whenever the enable is low. A lock flag is raised once the loop has shown a small phase error for a run of consecutive comparisons.

A power-save input switches the loop on and off. While power save is low, the block drops every pump command, clears the lock flag and reports the loop as open. When power save goes high, the block spends one cycle in an alignment state. During that cycle it pulses a resync output, so that both dividers restart from a common instant, and it clears its own comparator. The first comparison after start-up therefore begins at zero phase error, which gives a fast pull-in. Both divided inputs pass through a parameterised synchronizer before their rising edges are taken.

A four-state machine controls the block:
- SAVE: the loop is open. It is entered from reset and from any state when power save is low.
- ALIGN: one cycle with the resync pulse. It is entered from SAVE when power save goes high.
- ACQUIRE: the loop is closed and not yet locked. It is entered from ALIGN, or from LOCKED on a bad comparison.
- LOCKED: entered from ACQUIRE on the LOCK_CNT-th consecutive good comparison.

Top module: `phase_det_ctrl`

## Requirements
- R1: After reset, up_n and dn_n are 1, and pump_en, pump_up, lock, loop_active and div_resync are 0.
- R2: While pwr_on is 0 (state SAVE), loop_active is 0, lock is 0, pump_en is 0, and up_n and dn_n stay 1, whatever edges arrive on ref_in and div_in.
- R3: The edge that first samples pwr_on high enters ALIGN. For exactly that one cycle, div_resync is 1 and loop_active becomes 1. The next cycle is in ACQUIRE with div_resync 0.
- R4: A rising ref_in edge that leads a rising div_in edge by g cycles drives up_n low for g+1 cycles, dn_n low for 1 cycle, and pump_en with pump_up=1 for g cycles. The outputs follow the input edge after SYNC_STAGES+1 clock edges.
- R5: A rising div_in edge that leads ref_in by g cycles drives dn_n low for g+1 cycles, up_n low for 1 cycle, and pump_en for g cycles with pump_up=0.
- R6: A cycle with both up_n and dn_n low is always followed by a cycle with both high. This reset takes priority over new edges. Edges that arrive together give one shared low cycle and no pump_en.
- R7: lock rises after LOCK_CNT (default 8) consecutive comparisons whose error width is at most LOCK_TOL cycles (default 2). The error width is the number of cycles in which exactly one of the two commands is active.
- R8: One comparison whose error width exceeds LOCK_TOL clears lock at once, or restarts the consecutive count while the loop is acquiring.
- R9: Entering power save clears lock. After resuming, lock needs a fresh run of LOCK_CNT good comparisons.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for sampling and lock qualification |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Divided reference signal |
| div_in | input | 1 | Divided oscillator signal |
| pwr_on | input | 1 | Power-save control, 1 = operate, 0 = standby |
| up_n | output | 1 | Active-low raise command for an external pump |
| dn_n | output | 1 | Active-low lower command for an external pump |
| pump_en | output | 1 | Internal pump drive enable; 0 = high impedance |
| pump_up | output | 1 | Internal pump direction, 1 = source, 0 = sink |
| lock | output | 1 | Qualified lock flag, 1 = locked |
| loop_active | output | 1 | Loop-closed status, 0 during power save |
| div_resync | output | 1 | One-cycle pulse that restarts both dividers |

## Verification
On every cycle, the assertions check the standby invariants, the one-cycle resync pulse on entry to the loop, the forced release after any shared low cycle, and the agreement of pump_en and pump_up with the external pulses. Only the bench scenarios can show the pulse widths for each lead and lag and the exact latency from input edge to output. The same holds for the count of good comparisons before lock, the effect of a single wide error, and the requalification needed after standby.

// File: rtl/phase_det_pkg.sv
package phase_det_pkg;
    typedef enum logic [1:0] {
        ST_SAVE    = 2'd0,
        ST_ALIGN   = 2'd1,
        ST_ACQUIRE = 2'd2,
        ST_LOCKED  = 2'd3
    } pd_state_t;

    function automatic int clog2_min1(input int val);
        int w;
        w = 1;
        while ((1 << w) <= val) w++;
        return w;
    endfunction
endpackage

// File: rtl/phase_det_edge.sv
module phase_det_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic synced;
    logic prev_q;

    generate
        if (STAGES == 0) begin : g_nosync
            assign synced = sig_i;
        end else begin : g_sync
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], sig_i} & {STAGES{1'b1}};
            end
            assign synced = chain_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
    end

    assign rise_o = synced & ~prev_q;
endmodule

// File: rtl/phase_det_core.sv
module phase_det_core (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic ref_rise_i,
    input  logic div_rise_i,
    output logic up_o,
    output logic dn_o
);
    logic up_q, dn_q;
    logic both_set;

    assign both_set = up_q & dn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (!run_i || both_set) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_q | ref_rise_i;
            dn_q <= dn_q | div_rise_i;
        end
    end

    assign up_o = up_q;
    assign dn_o = dn_q;
endmodule

// File: rtl/phase_det_meter.sv
module phase_det_meter #(
    parameter int LOCK_TOL = 2,
    parameter int ERR_W    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic up_i,
    input  logic dn_i,
    output logic good_o,
    output logic bad_o
);
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
    localparam logic [ERR_W-1:0] TOL_V   = ERR_W'(LOCK_TOL);

    logic [ERR_W-1:0] err_q;
    logic             done;

    assign done = run_i & up_i & dn_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         err_q <= '0;
        else if (!run_i || done)            err_q <= '0;
        else if ((up_i ^ dn_i) && err_q != ERR_MAX) err_q <= err_q + 1'b1;
    end

    assign good_o = done & (err_q <= TOL_V);
    assign bad_o  = done & (err_q >  TOL_V);
endmodule

// File: rtl/phase_det_ctrl.sv
module phase_det_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_TOL    = 2,
    parameter int LOCK_CNT    = 8,
    parameter int ERR_W       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic div_in,
    input  logic pwr_on,
    output logic up_n,
    output logic dn_n,
    output logic pump_en,
    output logic pump_up,
    output logic lock,
    output logic loop_active,
    output logic div_resync
);
    import phase_det_pkg::*;

    localparam int CNT_W = clog2_min1(LOCK_CNT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CNT - 1);

    pd_state_t        state_q, state_d;
    logic [CNT_W-1:0] good_cnt_q, good_cnt_d;
    logic             run;
    logic             ref_rise, div_rise;
    logic             up, dn;
    logic             good, bad;

    assign run = (state_q == ST_ACQUIRE) || (state_q == ST_LOCKED);

    phase_det_edge #(.STAGES(SYNC_STAGES)) ref_edge_i (
        .clk(clk), .rst_n(rst_n), .sig_i(ref_in), .rise_o(ref_rise)
    );

    phase_det_edge #(.STAGES(SYNC_STAGES)) div_edge_i (
        .clk(clk), .rst_n(rst_n), .sig_i(div_in), .rise_o(div_rise)
    );

    phase_det_core core_i (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .ref_rise_i(ref_rise), .div_rise_i(div_rise),
        .up_o(up), .dn_o(dn)
    );

    phase_det_meter #(.LOCK_TOL(LOCK_TOL), .ERR_W(ERR_W)) meter_i (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .up_i(up), .dn_i(dn), .good_o(good), .bad_o(bad)
    );

    // next state and qualification counter
    always_comb begin
        state_d    = state_q;
        good_cnt_d = good_cnt_q;
        unique case (state_q)
            ST_SAVE: begin
                good_cnt_d = '0;
                if (pwr_on) state_d = ST_ALIGN;
            end
            ST_ALIGN: begin
                good_cnt_d = '0;
                state_d    = pwr_on ? ST_ACQUIRE : ST_SAVE;
            end
            ST_ACQUIRE: begin
                if (!pwr_on) begin
                    state_d    = ST_SAVE;
                    good_cnt_d = '0;
                end else if (bad) begin
                    good_cnt_d = '0;
                end else if (good) begin
                    if (good_cnt_q == CNT_LAST) begin
                        state_d    = ST_LOCKED;
                        good_cnt_d = '0;
                    end else begin
                        good_cnt_d = good_cnt_q + 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                good_cnt_d = '0;
                if (!pwr_on)  state_d = ST_SAVE;
                else if (bad) state_d = ST_ACQUIRE;
            end
            default: begin
                state_d    = ST_SAVE;
                good_cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_SAVE;
            good_cnt_q <= '0;
        end else begin
            state_q    <= state_d;
            good_cnt_q <= good_cnt_d;
        end
    end

    // outputs
    always_comb begin
        up_n        = ~(run & up);
        dn_n        = ~(run & dn);
        pump_en     = run & (up ^ dn);
        pump_up     = run & up & ~dn;
        lock        = (state_q == ST_LOCKED);
        loop_active = (state_q != ST_SAVE);
        div_resync  = (state_q == ST_ALIGN);
    end
endmodule

// File: rtl/phase_det_ctrl_chk.sv
module phase_det_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_on,
    input logic up_n,
    input logic dn_n,
    input logic pump_en,
    input logic pump_up,
    input logic lock,
    input logic loop_active,
    input logic div_resync
);
    // R2
    save_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_active |-> (up_n && dn_n && !pump_en && !lock));

    // R2
    pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> !loop_active);

    // R3
    resync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_active) |-> div_resync);

    // R3
    resync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_resync |=> !div_resync);

    // R6
    overlap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && !dn_n) |=> (up_n && dn_n));

    // R4
    pump_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_en |-> ((pump_up == !up_n) && (up_n != dn_n)));

    // R7
    lock_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (loop_active && !div_resync));
endmodule

bind phase_det_ctrl phase_det_ctrl_chk chk_i (.*);

// File: tb/phase_det_ctrl_tb_top.sv
module phase_det_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam int V_GAP [NV] = '{0, 1, 2, 3, 4, 1};
    localparam int V_REF [NV] = '{1, 1, 0, 1, 0, 0};
    localparam int V_UP  [NV] = '{1, 2, 1, 4, 1, 1};
    localparam int V_DN  [NV] = '{1, 1, 3, 1, 5, 2};
    localparam int V_EN  [NV] = '{0, 1, 2, 3, 4, 1};
    localparam int V_PU  [NV] = '{0, 1, 0, 3, 0, 0};

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_in = 1'b0, div_in = 1'b0, pwr_on = 1'b0;
    logic up_n, dn_n, pump_en, pump_up, lock, loop_active, div_resync;
    int checks = 0, errors = 0;
    int cu, cd, ce, cp, mark;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_det_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .div_in(div_in), .pwr_on(pwr_on),
        .up_n(up_n), .dn_n(dn_n), .pump_en(pump_en), .pump_up(pump_up),
        .lock(lock), .loop_active(loop_active), .div_resync(div_resync)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one comparison: lead edge, lag edge gap cycles later, count output cycles
    task automatic cmp(input bit ref_first, input int gap,
                       output int nu, output int nd, output int ne, output int np);
        nu = 0; nd = 0; ne = 0; np = 0;
        for (int i = 0; i < gap + 18; i++) begin
            @(negedge clk);
            nu += int'(!up_n); nd += int'(!dn_n);
            ne += int'(pump_en); np += int'(pump_en && pump_up);
            if (i == 0) begin
                if (ref_first) ref_in = 1'b1; else div_in = 1'b1;
            end
            if (i == gap) begin
                ref_in = 1'b1; div_in = 1'b1;
            end
            if (i == gap + 12) begin
                ref_in = 1'b0; div_in = 1'b0;
            end
        end
    endtask

    task automatic power_up();
        @(negedge clk); pwr_on = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic good_runs(input int n);
        for (int k = 0; k < n; k++) cmp(1'b1, 1, cu, cd, ce, cp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 up_n", up_n, 1); chk("R1 dn_n", dn_n, 1);
        chk("R1 pump_en", pump_en, 0); chk("R1 pump_up", pump_up, 0);
        chk("R1 lock", lock, 0); chk("R1 loop_active", loop_active, 0);
        chk("R1 div_resync", div_resync, 0);
        rst_n = 1'b1;

        // R2 edges in standby have no effect
        cmp(1'b1, 3, cu, cd, ce, cp);
        chk("R2 up_n low cycles", cu, 0); chk("R2 dn_n low cycles", cd, 0);
        chk("R2 pump_en cycles", ce, 0); chk("R2 loop_active", loop_active, 0);

        // R3 alignment pulse
        @(negedge clk); pwr_on = 1'b1;
        @(negedge clk);
        chk("R3 resync in ALIGN", div_resync, 1); chk("R3 loop_active", loop_active, 1);
        @(negedge clk);
        chk("R3 resync released", div_resync, 0); chk("R3 loop_active held", loop_active, 1);

        // R4 R5 R6 vector table
        for (int v = 0; v < NV; v++) begin
            cmp(V_REF[v] != 0, V_GAP[v], cu, cd, ce, cp);
            chk($sformatf("R4/R5 v%0d up_n low", v), cu, V_UP[v]);
            chk($sformatf("R4/R5 v%0d dn_n low", v), cd, V_DN[v]);
            chk($sformatf("R6 v%0d pump_en", v), ce, V_EN[v]);
            chk($sformatf("R4 v%0d pump_up", v), cp, V_PU[v]);
        end

        // R4 latency: ref edge visible after SYNC_STAGES+1 edges
        repeat (4) @(negedge clk);
        ref_in = 1'b1; mark = 0;
        for (int i = 1; i <= 6 && mark == 0; i++) begin
            @(negedge clk);
            if (!up_n) mark = i;
        end
        chk("R4 latency", mark, 3);
        div_in = 1'b1;
        repeat (8) @(negedge clk);
        ref_in = 1'b0; div_in = 1'b0;
        repeat (6) @(negedge clk);

        // R7 lock after 8 good comparisons from a fresh start
        @(negedge clk); pwr_on = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 lock in standby", lock, 0);
        power_up();
        good_runs(7);
        chk("R7 no lock after 7", lock, 0);
        good_runs(1);
        chk("R7 lock after 8", lock, 1);

        // R8 one wide error drops lock
        cmp(1'b0, 3, cu, cd, ce, cp);
        chk("R8 lock lost", lock, 0);

        // R8 bad comparison restarts the count
        good_runs(5);
        cmp(1'b1, 4, cu, cd, ce, cp);
        good_runs(7);
        chk("R8 count restarted", lock, 0);
        good_runs(1);
        chk("R8 relock", lock, 1);
        cmp(1'b1, 2, cu, cd, ce, cp);
        chk("R7 tolerance edge keeps lock", lock, 1);

        // R9 standby clears lock, requalification needed
        @(negedge clk); pwr_on = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 lock cleared", lock, 0);
        power_up();
        good_runs(7);
        chk("R9 no early lock", lock, 0);
        good_runs(1);
        chk("R9 requalified", lock, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule